// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor core that fetches one instruction from its own instruction memory array and finishes it in the same clock period. It supports register-format arithmetic and logic (add, sub, and, or, set-if-less-than), word load and store, branch-if-equal and an absolute jump. All instruction forms share one datapath:
- A program counter.
- A 32-entry register file with two combinational read ports and one write port that updates on the clock edge.
- An ALU.
- A sign extender.
- A data memory array.
- A decoder that sorts each instruction into a class and drives the operand, write-back, destination and next-PC selects.

Branch targets come from their own adder. The ALU zero flag decides whether a branch is taken.

There are no architectural states beyond the PC. The decoder classes act as the named per-cycle modes: REG, LOAD, STORE, BRANCH, JUMP and NOP. The next-PC transition is chosen from the class:
- PC+4 for REG, LOAD, STORE and NOP.
- PC+4 or the branch target for BRANCH.
- The jump target for JUMP.

Both memories are plain internal arrays that a test environment fills directly before reset is released. Commit activity is visible on the ports: the register write strobe, address and data, the data-memory write strobe, address and data, and the current PC.

Instruction fields: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, funct in 5:0, a 16-bit immediate in 15:0, and a 26-bit jump target in 25:0.

Top module: `onecycle_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 at the next rising edge. While `rst` is high, neither `rf_we_o` nor `dm_we_o` is asserted.
- R2: For any instruction that is not a taken branch or a jump, the next PC is PC+4.
- R3: Opcode 000000 uses funct to pick the operation and writes the result to register rd. The funct codes are 100000 add, 100010 sub, 100100 and, 100101 or and 101010 signed set-if-less-than, which gives 1 or 0.
- R4: Register 0 always reads as zero. A write aimed at it is dropped and `rf_we_o` stays low.
- R5: A load (opcode 100011) reads the data word at rs plus the sign-extended immediate and writes that word to register rt.
- R6: A store (opcode 101011) writes register rt to the data word at rs plus the sign-extended immediate. The store raises `dm_we_o` for that cycle and does not write any register.
- R7: Branch-if-equal (opcode 000100) compares rs and rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. When they differ, the next PC is PC+4.
- R8: A jump (opcode 000010) sets the PC to {PC+4 bits 31:28, target[25:0], 2'b00}.
- R9: Any other opcode, and opcode 000000 with any other funct, acts as a no-op. It writes nothing and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write commits at the coming edge |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written to the register file |
| dm_we_o | output | 1 | Data memory write commits at the coming edge |
| dm_addr_o | output | 32 | Data memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data written to memory (rt value) |

## Verification
The bench builds the core with 32 instruction words and 16 data words. This is enough for a 24-instruction program that runs every instruction class. The program also covers a negative load/store offset, a taken and a not-taken branch, a jump over dead code, a store followed by a load of the same word, and a backward branch that holds the PC in place. The small data array keeps every address the program touches inside the array, so the load of a previously stored word shows the store landed. A reset applied mid-program shows that the PC returns to 0 and that the pending load write is held off until reset is released.

// File: rtl/occ_pkg.sv
package occ_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OP_REG   = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND,
        ALU_OR,
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        IC_REG,
        IC_LOAD,
        IC_STORE,
        IC_BRANCH,
        IC_JUMP,
        IC_NOP
    } iclass_e;

    typedef struct packed {
        iclass_e cls;
        alu_op_e alu_op;
        logic    alu_src_imm;
        logic    wb_from_mem;
        logic    dst_rd;
        logic    reg_write;
        logic    mem_write;
    } ctrl_t;

endpackage

// File: rtl/occ_decoder.sv
module occ_decoder
    import occ_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{cls: IC_NOP, alu_op: ALU_ADD, alu_src_imm: 1'b0,
                 wb_from_mem: 1'b0, dst_rd: 1'b0, reg_write: 1'b0,
                 mem_write: 1'b0};
        unique case (opcode)
            OP_REG: begin
                ctrl.dst_rd = 1'b1;
                unique case (funct)
                    FN_ADD:  begin ctrl.cls = IC_REG; ctrl.alu_op = ALU_ADD; ctrl.reg_write = 1'b1; end
                    FN_SUB:  begin ctrl.cls = IC_REG; ctrl.alu_op = ALU_SUB; ctrl.reg_write = 1'b1; end
                    FN_AND:  begin ctrl.cls = IC_REG; ctrl.alu_op = ALU_AND; ctrl.reg_write = 1'b1; end
                    FN_OR:   begin ctrl.cls = IC_REG; ctrl.alu_op = ALU_OR;  ctrl.reg_write = 1'b1; end
                    FN_SLT:  begin ctrl.cls = IC_REG; ctrl.alu_op = ALU_SLT; ctrl.reg_write = 1'b1; end
                    default: ctrl.cls = IC_NOP;
                endcase
            end
            OP_LOAD: begin
                ctrl.cls         = IC_LOAD;
                ctrl.alu_src_imm = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OP_STORE: begin
                ctrl.cls         = IC_STORE;
                ctrl.alu_src_imm = 1'b1;
                ctrl.mem_write   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.cls    = IC_BRANCH;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctrl.cls = IC_JUMP;
            default: ctrl.cls = IC_NOP;
        endcase
    end

endmodule

// File: rtl/occ_alu.sv
module occ_alu
    import occ_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/occ_regfile.sv
module occ_regfile
    import occ_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0)
            regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/occ_wordmem.sv
module occ_wordmem #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
    import occ_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 256
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [RIDX-1:0] rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    localparam int IIW = $clog2(IMEM_WORDS);
    localparam int DIW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] pc_q, pc_next, pc4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr_w, imm_sx, rs_val, rt_val, alu_b, alu_y, dm_rdata;
    logic [RIDX-1:0] waddr;
    logic            alu_zero, rf_we, dm_we;
    ctrl_t           ctrl;

    occ_wordmem #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (1'b0),
        .idx   (pc_q[IIW+1:2]),
        .wdata ('0),
        .rdata (instr_w)
    );

    occ_decoder u_dec (
        .opcode (instr_w[31:26]),
        .funct  (instr_w[5:0]),
        .ctrl   (ctrl)
    );

    assign imm_sx = {{(XLEN-16){instr_w[15]}}, instr_w[15:0]};
    assign waddr  = ctrl.dst_rd ? instr_w[15:11] : instr_w[20:16];
    assign rf_we  = ctrl.reg_write && !rst && (waddr != '0);
    assign dm_we  = ctrl.mem_write && !rst;

    occ_regfile #(.W(XLEN), .NREG(1 << RIDX)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (waddr),
        .wdata   (rf_wdata_o),
        .raddr_a (instr_w[25:21]),
        .raddr_b (instr_w[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.alu_src_imm ? imm_sx : rt_val;

    occ_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    occ_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .idx   (alu_y[DIW+1:2]),
        .wdata (rt_val),
        .rdata (dm_rdata)
    );

    assign pc4     = pc_q + XLEN'(4);
    assign br_tgt  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_tgt = {pc4[XLEN-1:XLEN-4], instr_w[25:0], 2'b00};

    always_comb begin
        unique case (ctrl.cls)
            IC_BRANCH: pc_next = alu_zero ? br_tgt : pc4;
            IC_JUMP:   pc_next = jmp_tgt;
            default:   pc_next = pc4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

endmodule

// File: rtl/occ_checker.sv
module occ_checker
    import occ_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] instr,
    input logic            rf_we_o,
    input logic [RIDX-1:0] rf_waddr_o,
    input logic            dm_we_o
);

    logic [5:0]      opc;
    logic [XLEN-1:0] pc4, jtgt, btgt;

    assign opc  = instr[31:26];
    assign pc4  = pc_o + XLEN'(4);
    assign jtgt = {pc4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
    assign btgt = pc4 + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    AST_RST_PC_ZERO: assert property (@(posedge clk) rst |=> pc_o == '0); // R1
    AST_RST_NO_WRITE: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o)); // R1
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (opc != OP_BEQ && opc != OP_JUMP) |=> pc_o == $past(pc_o) + XLEN'(4)); // R2
    AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> rf_waddr_o != '0); // R4
    AST_STORE_NO_REG: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_o && dm_we_o)); // R6
    AST_BRANCH_PC: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ) |=> (pc_o == $past(pc4) || pc_o == $past(btgt))); // R7
    AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_JUMP) |=> pc_o == $past(jtgt)); // R8

endmodule

bind onecycle_core occ_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr      (instr_w),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .dm_we_o    (dm_we_o)
);

// File: tb/onecycle_core_tb_top.sv
`timescale 1ns/1ps
module onecycle_core_tb_top;

    localparam int IW = 32;
    localparam int DW = 16;
    localparam int NPROG = 24;
    localparam int NVEC = 20;

    function automatic logic [31:0] f_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
    endfunction
    function automatic logic [31:0] f_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] f_j(logic [25:0] t);
        return {6'b000010, t};
    endfunction

    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BQ = 6'b000100;
    localparam logic [5:0] FADD = 6'b100000, FSUB = 6'b100010, FAND = 6'b100100,
                           FOR = 6'b100101, FSLT = 6'b101010;

    localparam logic [31:0] PROG [NPROG] = '{
        f_i(LW, 0, 1, 16'd0),        // 00 r1 = 7
        f_i(LW, 0, 2, 16'd4),        // 04 r2 = -3
        f_r(1, 2, 3, FADD),          // 08
        f_r(1, 2, 4, FSUB),          // 0C
        f_r(1, 2, 5, FAND),          // 10
        f_r(1, 2, 6, FOR),           // 14
        f_r(2, 1, 7, FSLT),          // 18
        f_r(1, 2, 8, FSLT),          // 1C
        f_r(1, 1, 0, FADD),          // 20 write to r0
        f_i(SW, 0, 0, 16'd12),       // 24 store r0
        f_i(LW, 3, 9, 16'hFFFC),     // 28 negative offset
        f_i(BQ, 1, 2, 16'd5),        // 2C not taken
        f_i(BQ, 1, 9, 16'd2),        // 30 taken -> 3C
        f_r(1, 1, 10, FADD),         // 34 skipped
        f_r(1, 1, 10, FADD),         // 38 skipped
        32'hFC00_0000,               // 3C unknown opcode
        f_r(1, 1, 12, 6'b000001),    // 40 unknown funct
        f_j(26'h14),                 // 44 jump -> 50
        f_r(1, 1, 13, FADD),         // 48 skipped
        f_r(1, 1, 13, FADD),         // 4C skipped
        f_i(SW, 3, 6, 16'hFFFC),     // 50 store -1 to word 0
        f_i(LW, 0, 11, 16'd0),       // 54 read it back
        f_i(BQ, 0, 0, 16'hFFFF),     // 58 self loop
        32'h0000_0000
    };

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] pc;
        logic        rfwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dmwe;
        logic [31:0] da;
        logic [31:0] dd;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{"R5", 32'h00, 1'b1, 5'd1,  32'h7,        1'b0, 32'h0, 32'h0},
        '{"R5", 32'h04, 1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'h0, 32'h0},
        '{"R3", 32'h08, 1'b1, 5'd3,  32'h4,        1'b0, 32'h0, 32'h0},
        '{"R3", 32'h0C, 1'b1, 5'd4,  32'hA,        1'b0, 32'h0, 32'h0},
        '{"R3", 32'h10, 1'b1, 5'd5,  32'h5,        1'b0, 32'h0, 32'h0},
        '{"R3", 32'h14, 1'b1, 5'd6,  32'hFFFFFFFF, 1'b0, 32'h0, 32'h0},
        '{"R3", 32'h18, 1'b1, 5'd7,  32'h1,        1'b0, 32'h0, 32'h0},
        '{"R3", 32'h1C, 1'b1, 5'd8,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R4", 32'h20, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R4", 32'h24, 1'b0, 5'd0,  32'h0,        1'b1, 32'hC, 32'h0},
        '{"R5", 32'h28, 1'b1, 5'd9,  32'h7,        1'b0, 32'h0, 32'h0},
        '{"R7", 32'h2C, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R7", 32'h30, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R9", 32'h3C, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R9", 32'h40, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R8", 32'h44, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R6", 32'h50, 1'b0, 5'd0,  32'h0,        1'b1, 32'h0, 32'hFFFFFFFF},
        '{"R6", 32'h54, 1'b1, 5'd11, 32'hFFFFFFFF, 1'b0, 32'h0, 32'h0},
        '{"R7", 32'h58, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0},
        '{"R7", 32'h58, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    onecycle_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < IW; i++)
            dut_i.u_imem.mem[i] = (i < NPROG) ? PROG[i] : 32'h0;
        for (int i = 0; i < DW; i++)
            dut_i.u_dmem.mem[i] = 32'h0;
        dut_i.u_dmem.mem[0] = 32'h7;
        dut_i.u_dmem.mem[1] = 32'hFFFF_FFFD;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset pc", pc_o, 32'h0);
        chk("R1", "reset rf_we", {31'b0, rf_we_o}, 32'h0);
        chk("R1", "reset dm_we", {31'b0, dm_we_o}, 32'h0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            #1;
            chk(string'(VEC[v].tag), "pc", pc_o, VEC[v].pc);
            chk(string'(VEC[v].tag), "rf_we", {31'b0, rf_we_o}, {31'b0, VEC[v].rfwe});
            if (VEC[v].rfwe) begin
                chk(string'(VEC[v].tag), "rf_waddr", {27'b0, rf_waddr_o}, {27'b0, VEC[v].wa});
                chk(string'(VEC[v].tag), "rf_wdata", rf_wdata_o, VEC[v].wd);
            end
            chk(string'(VEC[v].tag), "dm_we", {31'b0, dm_we_o}, {31'b0, VEC[v].dmwe});
            if (VEC[v].dmwe) begin
                chk(string'(VEC[v].tag), "dm_addr", dm_addr_o, VEC[v].da);
                chk(string'(VEC[v].tag), "dm_wdata", dm_wdata_o, VEC[v].dd);
            end
            @(negedge clk);
        end

        // R1: reset mid-program; instruction 0 is a load that must stay held
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "mid-run reset pc", pc_o, 32'h0);
        chk("R1", "mid-run reset rf_we", {31'b0, rf_we_o}, 32'h0);
        chk("R1", "mid-run reset dm_we", {31'b0, dm_we_o}, 32'h0);
        rst = 1'b0;
        #1;
        chk("R5", "load write after reset release", {31'b0, rf_we_o}, 32'h1);
        @(negedge clk);
        #1;
        chk("R2", "pc after first instruction", pc_o, 32'h4);

        done = 1'b1;
        report();
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule